// File: doc/BRIEF.md
# JTAG Identifier Probe Engine

This block tries one candidate assignment of test-clock, mode-select and data-out roles to the channels of a target whose pinout is unknown. It generates a divided test clock and forces the test access port into its reset state with a run of mode-select ones. It then steps the port into the data-shift state and clocks out 32 bits from the candidate data-out channel, least significant bit first. The data-in line is never driven with meaningful data. No instruction is loaded, so the block relies on the reset default. A device that has an identifier presents it. A device without one falls back to the one-bit pass-through register, whose first bit out is zero.

When the scan is finished, the block decides whether the word is plausible. A word of all ones is rejected, because it typically means that nothing is driving the data-out line. A word whose bit 0 is clear is also rejected, because it typically means a pass-through register or noise. The outer controller selects the channel roles, the clock divider and the order in which permutations are tried. For each attempt it pulses `start_i` and reads back the done pulse, the verdict, the word and the manufacturer field, bits [11:1].

Top module: `jtag_id_probe`

## Requirements
- R1: Each probe begins with five test-clock rising edges while mode-select is 1, so the target port reaches its reset state from any state it was left in.
- R2: The test clock stays low while the block is idle. During a probe, each high phase and each low phase lasts `div_i`+1 system clock cycles.
- R3: The mode-select line changes only in the system clock cycle in which the test clock falls. Its value while idle is 1.
- R4: After the reset run, mode-select follows 0, 1, 0, 0 on successive rising edges to reach the data-shift state. The next 32 rising edges each sample the data-out channel, and the first sample becomes bit 0 of the word.
- R5: Mode-select is 1 on the rising edge that takes the 32nd sample. It is 1 on the next edge and 0 on the edge after that, which leaves the target in its idle run state.
- R6: `valid_o` is 1 only when the captured word is not 32'hFFFFFFFF and its bit 0 is 1.
- R7: `done_o` is a single-cycle pulse. `id_o`, `valid_o` and `mfr_o` (always equal to `id_o[11:1]`) take new values in the same cycle and hold them until the next probe ends.
- R8: The test-clock channel and the mode-select channel are driven with those signals. The data-out channel alone has its output enable at 0. Every other channel is driven high with its enable at 1.
- R9: A `start_i` pulse that arrives while a probe is running is ignored.
- R10: A probe issues exactly 43 test-clock rising edges and ends with the test clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a probe |
| div_i | input | DIV_W | Test-clock half period minus one, in system cycles |
| tck_sel_i | input | SEL_W | Channel given the test-clock role |
| tms_sel_i | input | SEL_W | Channel given the mode-select role |
| tdo_sel_i | input | SEL_W | Channel read as target data-out |
| chan_i | input | CH | Levels read back from the target channels |
| chan_o | output | CH | Levels driven onto the target channels |
| chan_oe_o | output | CH | Per-channel output enable |
| busy_o | output | 1 | A probe is in progress |
| done_o | output | 1 | Probe finished (one-cycle pulse) |
| valid_o | output | 1 | Captured word passed the plausibility rules |
| id_o | output | 32 | Captured word |
| mfr_o | output | 11 | Manufacturer field of the captured word |

## Verification
The assertions check several properties on every cycle. The test clock is low whenever the block is idle, and mode-select moves only when the test clock falls. No strobe fires outside a probe, and a start that arrives during a scan leaves the scan running. `done_o` never lasts more than one cycle, a valid verdict always comes with bit 0 set and a word that is not all ones, and exactly one channel is left undriven. Other properties appear only when the bench's model of a target port answers the generated waveform: recovery from arbitrary prior port states, the bit order and timing of the shifted word, and the state the port is left in. The same holds for the pass-through and unconnected outcomes, the exact high-phase width for each divider value, and the total count of rising edges.

// File: rtl/jprobe_pkg.sv
package jprobe_pkg;

  localparam int ID_W        = 32;
  localparam int RESET_EDGES = 5;
  // reset run, then idle-run, select-DR, capture-DR, enter shift-DR
  localparam int SHIFT_FIRST = RESET_EDGES + 4;
  localparam int SHIFT_LAST  = SHIFT_FIRST + ID_W - 1;
  // exit1 on SHIFT_LAST, update on +1, back to idle-run on +2
  localparam int LAST_EDGE   = SHIFT_LAST + 2;
  localparam int EDGE_W      = $clog2(LAST_EDGE + 2);
  localparam int MFR_LSB     = 1;
  localparam int MFR_W       = 11;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_t;

  // Mode-select value to present before rising edge number e (0-based).
  function automatic logic tms_for(input int unsigned e);
    if (e < RESET_EDGES)          return 1'b1;
    if (e == RESET_EDGES)         return 1'b0;
    if (e == RESET_EDGES + 1)     return 1'b1;
    if (e <= SHIFT_LAST - 1)      return 1'b0;
    if (e <= SHIFT_LAST + 1)      return 1'b1;
    if (e == LAST_EDGE)           return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/jprobe_tck.sv
module jprobe_tck #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tck_q, tck_d;
  logic             hit;

  always_comb begin
    hit    = run_i && (cnt_q == div_i);
    rise_o = hit && !tck_q;
    fall_o = hit && tck_q;
    cnt_d  = cnt_q;
    tck_d  = tck_q;
    if (!run_i) begin
      cnt_d = '0;
      tck_d = 1'b0;
    end else if (hit) begin
      cnt_d = '0;
      tck_d = ~tck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tck_q <= tck_d;
    end
  end

  assign tck_o = tck_q;

  // a rising strobe is always followed by a high test clock
  p_rise_then_high_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> tck_o);

endmodule

// File: rtl/jprobe_seq.sv
module jprobe_seq
  import jprobe_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            tck_i,
  input  logic            tdo_i,
  output logic            busy_o,
  output logic            tms_o,
  output logic            fin_o,
  output logic [ID_W-1:0] word_o
);

  seq_state_t        state_q, state_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              tms_q, tms_d;
  logic [ID_W-1:0]   sh_q, sh_d;
  logic              in_shift, sh_en;

  always_comb begin
    in_shift = (edge_q >= EDGE_W'(SHIFT_FIRST)) && (edge_q <= EDGE_W'(SHIFT_LAST));
    sh_en    = (state_q == SQ_RUN) && rise_i && in_shift;
    fin_o    = (state_q == SQ_RUN) && fall_i && (edge_q == EDGE_W'(LAST_EDGE + 1));
    state_d  = state_q;
    edge_d   = edge_q;
    tms_d    = tms_q;
    sh_d     = sh_en ? {tdo_i, sh_q[ID_W-1:1]} : sh_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          state_d = SQ_RUN;
          edge_d  = '0;
          tms_d   = 1'b1;
        end
      end
      SQ_RUN: begin
        if (rise_i) edge_d = edge_q + 1'b1;
        if (fall_i) begin
          tms_d = tms_for(int'(edge_q));
          if (fin_o) state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      edge_q  <= '0;
      tms_q   <= 1'b1;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      tms_q   <= tms_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

  assign busy_o = (state_q == SQ_RUN);
  assign tms_o  = tms_q;
  assign word_o = sh_q;

  p_tms_on_fall_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tms_q) |-> $fell(tck_i));

  p_no_edge_idle_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_IDLE) |-> !rise_i);

  p_start_ignored_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !fin_o) |=> busy_o);

endmodule

// File: rtl/jprobe_judge.sv
module jprobe_judge
  import jprobe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ID_W-1:0]  word_i,
  output logic             done_o,
  output logic             valid_o,
  output logic [ID_W-1:0]  id_o,
  output logic [MFR_W-1:0] mfr_o
);

  logic verdict;

  always_comb verdict = word_i[0] && !(&word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      id_o    <= '0;
      mfr_o   <= '0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        valid_o <= verdict;
        id_o    <= word_i;
        mfr_o   <= word_i[MFR_LSB +: MFR_W];
      end
    end
  end

  p_done_pulse_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_valid_rule_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> (id_o[0] && (id_o != {ID_W{1'b1}})));

endmodule

// File: rtl/jprobe_pins.sv
module jprobe_pins #(
  parameter int CH    = 8,
  parameter int SEL_W = $clog2(CH)
) (
  input  logic             tck_i,
  input  logic             tms_i,
  input  logic [SEL_W-1:0] tck_sel_i,
  input  logic [SEL_W-1:0] tms_sel_i,
  input  logic [SEL_W-1:0] tdo_sel_i,
  input  logic [CH-1:0]    chan_i,
  output logic [CH-1:0]    chan_o,
  output logic [CH-1:0]    chan_oe_o,
  output logic             tdo_o
);

  for (genvar g = 0; g < CH; g++) begin : g_chan
    always_comb begin
      if (tck_sel_i == SEL_W'(g))      chan_o[g] = tck_i;
      else if (tms_sel_i == SEL_W'(g)) chan_o[g] = tms_i;
      else                             chan_o[g] = 1'b1;
      chan_oe_o[g] = (tdo_sel_i != SEL_W'(g));
    end
  end

  always_comb begin
    tdo_o = 1'b1;
    for (int i = 0; i < CH; i++) begin
      if (tdo_sel_i == SEL_W'(i)) tdo_o = chan_i[i];
    end
  end

endmodule

// File: rtl/jtag_id_probe.sv
module jtag_id_probe
  import jprobe_pkg::*;
#(
  parameter int CH    = 8,
  parameter int DIV_W = 8,
  parameter int SEL_W = $clog2(CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [SEL_W-1:0] tck_sel_i,
  input  logic [SEL_W-1:0] tms_sel_i,
  input  logic [SEL_W-1:0] tdo_sel_i,
  input  logic [CH-1:0]    chan_i,
  output logic [CH-1:0]    chan_o,
  output logic [CH-1:0]    chan_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic [31:0]      id_o,
  output logic [10:0]      mfr_o
);

  logic            tck, rise, fall, tms, tdo, fin;
  logic [ID_W-1:0] word;

  jprobe_tck #(.DIV_W(DIV_W)) i_tck (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (busy_o), .div_i (div_i),
    .tck_o (tck), .rise_o (rise), .fall_o (fall)
  );

  jprobe_seq i_seq (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i),
    .rise_i (rise), .fall_i (fall), .tck_i (tck), .tdo_i (tdo),
    .busy_o (busy_o), .tms_o (tms), .fin_o (fin), .word_o (word)
  );

  jprobe_judge i_judge (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (fin), .word_i (word),
    .done_o (done_o), .valid_o (valid_o), .id_o (id_o), .mfr_o (mfr_o)
  );

  jprobe_pins #(.CH(CH), .SEL_W(SEL_W)) i_pins (
    .tck_i (tck), .tms_i (tms),
    .tck_sel_i (tck_sel_i), .tms_sel_i (tms_sel_i), .tdo_sel_i (tdo_sel_i),
    .chan_i (chan_i), .chan_o (chan_o), .chan_oe_o (chan_oe_o), .tdo_o (tdo)
  );

  p_idle_tck_low_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tck);

  p_one_input_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~chan_oe_o) == 1);

endmodule

// File: tb/test_jtag_id_probe.sv
module test_jtag_id_probe;

  localparam int CLK_PERIOD = 10;
  localparam int CH = 8;
  localparam int DIV_W = 8;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] P_TCK = 3'd2, P_TMS = 3'd5, P_TDO = 3'd1, P_TDI = 3'd6;

  logic clk, rst_n, start;
  logic [DIV_W-1:0] div;
  logic [SEL_W-1:0] tck_sel, tms_sel, tdo_sel;
  logic [CH-1:0] chan_i, chan_o, chan_oe;
  logic busy, done, valid;
  logic [31:0] id;
  logic [10:0] mfr;

  jtag_id_probe #(.CH(CH), .DIV_W(DIV_W)) i_jtag_id_probe (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_i(div),
    .tck_sel_i(tck_sel), .tms_sel_i(tms_sel), .tdo_sel_i(tdo_sel),
    .chan_i(chan_i), .chan_o(chan_o), .chan_oe_o(chan_oe),
    .busy_o(busy), .done_o(done), .valid_o(valid), .id_o(id), .mfr_o(mfr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- target port model ----------------
  typedef enum logic [3:0] {
    T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PDR, T_EX2DR, T_UPDR,
    T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PIR, T_EX2IR, T_UPIR
  } tap_t;

  tap_t tst;
  logic [31:0] tsr, t_id;
  logic t_has_id, t_tdo, t_tck, t_tms, t_tdi;
  int t_edges;

  assign t_tck = chan_o[P_TCK];
  assign t_tms = chan_o[P_TMS];
  assign t_tdi = chan_o[P_TDI];

  always_comb begin
    for (int i = 0; i < CH; i++) chan_i[i] = (P_TDO == SEL_W'(i)) ? t_tdo : 1'b1;
  end

  function automatic tap_t tap_next(tap_t s, logic m);
    case (s)
      T_TLR:   return m ? T_TLR   : T_RTI;
      T_RTI:   return m ? T_SELDR : T_RTI;
      T_SELDR: return m ? T_SELIR : T_CAPDR;
      T_CAPDR: return m ? T_EX1DR : T_SHDR;
      T_SHDR:  return m ? T_EX1DR : T_SHDR;
      T_EX1DR: return m ? T_UPDR  : T_PDR;
      T_PDR:   return m ? T_EX2DR : T_PDR;
      T_EX2DR: return m ? T_UPDR  : T_SHDR;
      T_UPDR:  return m ? T_SELDR : T_RTI;
      T_SELIR: return m ? T_TLR   : T_CAPIR;
      T_CAPIR: return m ? T_EX1IR : T_SHIR;
      T_SHIR:  return m ? T_EX1IR : T_SHIR;
      T_EX1IR: return m ? T_UPIR  : T_PIR;
      T_PIR:   return m ? T_EX2IR : T_PIR;
      T_EX2IR: return m ? T_UPIR  : T_SHIR;
      default: return m ? T_SELDR : T_RTI;
    endcase
  endfunction

  always @(posedge t_tck) begin
    t_edges <= t_edges + 1;
    if (tst == T_CAPDR) tsr <= t_has_id ? t_id : 32'h0;
    else if (tst == T_SHDR) begin
      if (t_has_id) tsr <= {t_tdi, tsr[31:1]};
      else          tsr[0] <= t_tdi;
    end
    tst <= tap_next(tst, t_tms);
  end

  always @(negedge t_tck) t_tdo <= (tst == T_SHDR) ? tsr[0] : 1'b1;

  // ---------------- scoreboard ----------------
  typedef struct { logic [31:0] w; logic v; } exp_t;
  exp_t q[$];
  int checks, fails, dones, r3_bad, hi_cnt, last_hi;
  logic done_prev, prev_tck, prev_tms;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev) chk(!done, "R7", "done pulse width", done, 0);
      done_prev = done;
      if (done) begin
        dones++;
        if (q.size() == 0) chk(0, "R7", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(id == e.w, "R4", "captured word", id, e.w);
          chk(valid == e.v, "R6", "verdict", valid, e.v);
          chk(mfr == e.w[11:1], "R7", "manufacturer field", mfr, e.w[11:1]);
        end
      end
      // R3: mode-select line moves only with a falling test clock
      if (busy && (chan_o[tms_sel] != prev_tms) && !(prev_tck && !chan_o[tck_sel]))
        r3_bad++;
      if (chan_o[tck_sel]) hi_cnt++;
      else if (hi_cnt != 0) begin last_hi = hi_cnt; hi_cnt = 0; end
    end
    prev_tck = chan_o[tck_sel];
    prev_tms = chan_o[tms_sel];
  end

  task automatic run_probe(input logic [31:0] idv, input bit has, input tap_t s0,
                           input logic [DIV_W-1:0] d, input bit tdo_ok, input bit restart);
    logic [31:0] w;
    logic [CH-1:0] um;
    int n;
    exp_t e;
    @(negedge clk);
    div = d; tck_sel = P_TCK; tms_sel = P_TMS; tdo_sel = tdo_ok ? P_TDO : 3'd3;
    repeat (2) @(negedge clk);
    t_has_id = has; t_id = idv;
    tst <= s0; t_edges <= 0; t_tdo <= 1'b1;
    @(negedge clk);
    w = !tdo_ok ? 32'hFFFF_FFFF : (has ? idv : 32'hFFFF_FFFE);
    e.w = w; e.v = (w != 32'hFFFF_FFFF) && w[0];
    q.push_back(e);
    n = dones;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    um = ~((CH'(1) << tck_sel) | (CH'(1) << tms_sel));
    chk((chan_o & um) == um, "R8", "unused channels high", chan_o, um);
    chk(chan_oe == ~(CH'(1) << tdo_sel), "R8", "output enables", chan_oe, ~(CH'(1) << tdo_sel));
    if (restart) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    for (int k = 0; k < 3000 && dones == n; k++) @(negedge clk);
    chk(dones == n + 1, "R7", "probe completion", dones, n + 1);
    repeat (40) @(negedge clk);
    chk(dones == n + 1, "R9", "single completion per probe", dones, n + 1);
    chk(t_edges == 43, "R10", "rising edge count", t_edges, 43);
    chk(tst == T_RTI, "R5", "target left in idle run", tst, T_RTI);
    chk(last_hi == int'(d) + 1, "R2", "high phase width", last_hi, int'(d) + 1);
    chk(!busy && !chan_o[tck_sel], "R2", "idle test clock low", chan_o[tck_sel], 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finished");
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0; dones = 0; r3_bad = 0; hi_cnt = 0; last_hi = 0;
    done_prev = 1'b0; prev_tck = 1'b0; prev_tms = 1'b1;
    rst_n = 1'b0; start = 1'b0; div = 8'd1;
    tck_sel = P_TCK; tms_sel = P_TMS; tdo_sel = P_TDO;
    t_has_id = 1'b1; t_id = 32'h0; tst = T_TLR; tsr = 32'h0; t_tdo = 1'b1; t_edges = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !valid && id == 32'h0, "R7", "reset outputs", {busy, done, valid}, 0);
    chk(chan_o[P_TCK] == 1'b0, "R2", "reset test clock low", chan_o[P_TCK], 0);
    chk(chan_o[P_TMS] == 1'b1, "R3", "reset mode-select high", chan_o[P_TMS], 1);

    run_probe(32'h0471_017F, 1'b1, T_TLR,   8'd1, 1'b1, 1'b0); // R4 R6 valid id
    run_probe(32'h01C0_601D, 1'b1, T_SHIR,  8'd0, 1'b1, 1'b0); // R1 from shift-IR
    run_probe(32'h1F0F_0F0F, 1'b1, T_PDR,   8'd3, 1'b1, 1'b1); // R1 R9 restart ignored
    run_probe(32'h0,         1'b0, T_EX2IR, 8'd1, 1'b1, 1'b0); // R6 pass-through
    run_probe(32'h1234_5678, 1'b1, T_UPIR,  8'd2, 1'b1, 1'b0); // R6 bit0 clear
    run_probe(32'h0,         1'b1, T_RTI,   8'd1, 1'b0, 1'b0); // R6 all ones
    run_probe(32'h8000_0001, 1'b1, T_SELIR, 8'd0, 1'b1, 1'b0); // R4 boundary bits

    chk(r3_bad == 0, "R3", "mode-select change outside falling edge", r3_bad, 0);
    chk(q.size() == 0, "R7", "expected items left", q.size(), 0);
    summary();
    $finish;
  end

endmodule